// File: doc/BRIEF.md
# Selector-Ordered Hash Round Sequencer

This block runs a chain of sixteen hash rounds whose order is decided at run time. A 64-bit selector word, taken from the trailing bytes of the preceding block's hash, is split into sixteen 4-bit digits. Each digit names one of sixteen hash engine types, and each digit drives one round. The engines sit outside the block behind a single valid/ready request port and a valid response port. The block sends the current 512-bit word and an engine index to that port, waits for the answer, and feeds the answer into the next round. The answer to the sixteenth round is the chain result.

Software-free use looks like this. The caller pulses `start` together with a selector and an initial message while the block is idle. The block then walks the digits from the most significant one to the least significant one. It pulses `done` when the last answer returns. Because the digits are arbitrary, one engine may serve several rounds and another may serve none. The block therefore also reports how many different engine types the loaded selector calls on. A selector stays in force for a whole chain and changes only at the next accepted start.

Top module: `hchain_seq`

## Requirements
- R1: A synchronous reset, whether at power-up or in the middle of a chain, leaves `req_valid`, `busy` and `done` low and `distinct_cnt` at 0 on the next cycle.
- R2: A `start` pulse seen while idle captures `selector` and `msg_in`. `busy` is high on the next cycle and the first request carries `req_data` equal to the captured message.
- R3: Round k (k = 0..15) requests engine `selector[63-4k -: 4]`. Round 0 uses bits 63:60 and round 15 uses bits 3:0.
- R4: For k > 0 the `req_data` of round k equals the `resp_data` returned for round k-1. Only one request is outstanding: `req_valid` is low from the cycle after `req_ready` is accepted until a response arrives.
- R5: While `req_valid` is high and `req_ready` is low, the request stays asserted with `req_engine` and `req_data` unchanged.
- R6: A `resp_valid` pulse that arrives while no request has been accepted is ignored. It neither advances the chain nor alters the data passed on.
- R7: One cycle after the sixteenth response, `done` is high for exactly one cycle, `busy` is low and `result` equals that response. `result` keeps this value afterwards.
- R8: A `start` pulse while `busy` is high is ignored. The running chain keeps its selector, its data and its distinct count.
- R9: From the cycle after an accepted start, `distinct_cnt` equals the number of different 4-bit values among the selector's sixteen digits, from 1 to 16. It holds this value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain (honoured only when idle) |
| selector | input | 64 | Round-order word, sixteen 4-bit engine digits |
| msg_in | input | 512 | Initial message for round 0 |
| busy | output | 1 | A chain is in progress |
| done | output | 1 | One-cycle pulse when the chain completes |
| result | output | 512 | Output of the final round |
| distinct_cnt | output | 5 | Number of different engine types in the loaded selector |
| req_valid | output | 1 | Request to an engine is pending |
| req_ready | input | 1 | Engine port accepts the request |
| req_engine | output | 4 | Engine index for the current round |
| req_data | output | 512 | Input word for the current round |
| resp_valid | input | 1 | Engine answer is present |
| resp_data | input | 512 | Engine answer |

## Verification
Selectors with all sixteen digits different show whether the digit walk is MSB-first rather than reversed. An all-zero word and a two-value pattern test the distinct count at its lower end and check repeated use of one engine. Random selectors and messages, with random accept and response delays, separate a correct hand-over of data between rounds from a stale or skipped one. Directed runs add a stray response before acceptance, a second start in mid-chain and a reset in mid-chain, which expose a block that does not ignore these inputs or does not fully clear its state.

// File: rtl/hchain_pkg.sv
package hchain_pkg;

    localparam int STAGES    = 16;
    localparam int ENG_W     = 4;
    localparam int SEL_W     = STAGES * ENG_W;
    localparam int DATA_W    = 512;
    localparam int ENG_TYPES = 1 << ENG_W;
    localparam int CNT_W     = $clog2(ENG_TYPES + 1);
    localparam int STG_W     = $clog2(STAGES);

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_ISSUE = 2'd1,
        CS_WAIT  = 2'd2
    } chain_state_e;

    typedef struct packed {
        logic [ENG_W-1:0]  engine;
        logic [DATA_W-1:0] data;
    } hreq_t;

    function automatic logic is_last_stage(input logic [STG_W-1:0] stg);
        return stg == STG_W'(STAGES - 1);
    endfunction

endpackage

// File: rtl/hchain_nib_pick.sv
module hchain_nib_pick
    import hchain_pkg::*;
#(
    parameter int N_STG = STAGES,
    parameter int DW    = ENG_W,
    localparam int SW   = N_STG * DW,
    localparam int IW   = $clog2(N_STG)
) (
    input  logic [SW-1:0] sel_word,
    input  logic [IW-1:0] stage_idx,
    output logic [DW-1:0] digit
);
    logic [N_STG-1:0][DW-1:0] digits;

    // Stage 0 maps to the most significant digit.
    for (genvar g = 0; g < N_STG; g++) begin : g_dig
        assign digits[g] = sel_word[SW-1-g*DW -: DW];
    end

    assign digit = digits[stage_idx];
endmodule

// File: rtl/hchain_distinct.sv
module hchain_distinct
    import hchain_pkg::*;
#(
    parameter int N_STG = STAGES,
    parameter int DW    = ENG_W,
    localparam int SW   = N_STG * DW,
    localparam int NV   = 1 << DW,
    localparam int CW   = $clog2(NV + 1)
) (
    input  logic [SW-1:0] sel_word,
    output logic [CW-1:0] count
);
    logic [NV-1:0] present;

    for (genvar v = 0; v < NV; v++) begin : g_val
        logic [N_STG-1:0] hit;
        for (genvar s = 0; s < N_STG; s++) begin : g_stg
            assign hit[s] = (sel_word[s*DW +: DW] == DW'(v));
        end
        assign present[v] = |hit;
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < NV; i++) begin
            count = count + CW'(present[i]);
        end
    end
endmodule

// File: rtl/hchain_ctrl.sv
module hchain_ctrl
    import hchain_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int N_STG   = STAGES,
    localparam int IW     = $clog2(N_STG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] msg_in,
    input  logic          req_ready,
    input  logic          resp_valid,
    input  logic [DW-1:0] resp_data,
    output chain_state_e  state,
    output logic [IW-1:0] stage,
    output logic [DW-1:0] cur_data,
    output logic          load,
    output logic          done,
    output logic [DW-1:0] result
);
    logic last;

    assign load = (state == CS_IDLE) && start;
    assign last = (stage == IW'(N_STG - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CS_IDLE;
            stage    <= '0;
            cur_data <= '0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                CS_IDLE: begin
                    if (start) begin
                        state    <= CS_ISSUE;
                        stage    <= '0;
                        cur_data <= msg_in;
                    end
                end
                CS_ISSUE: begin
                    if (req_ready) begin
                        state <= CS_WAIT;
                    end
                end
                CS_WAIT: begin
                    if (resp_valid) begin
                        cur_data <= resp_data;
                        if (last) begin
                            state  <= CS_IDLE;
                            result <= resp_data;
                            done   <= 1'b1;
                        end else begin
                            state <= CS_ISSUE;
                            stage <= stage + 1'b1;
                        end
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hchain_seq.sv
module hchain_seq
    import hchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEL_W-1:0]  selector,
    input  logic [DATA_W-1:0] msg_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [CNT_W-1:0]  distinct_cnt,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ENG_W-1:0]  req_engine,
    output logic [DATA_W-1:0] req_data,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data
);
    chain_state_e      state;
    logic [STG_W-1:0]  stage;
    logic [DATA_W-1:0] cur_data;
    logic              load;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  cnt_next;
    logic [ENG_W-1:0]  digit;
    hreq_t             req;

    hchain_ctrl #(.DW(DATA_W), .N_STG(STAGES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .msg_in     (msg_in),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .state      (state),
        .stage      (stage),
        .cur_data   (cur_data),
        .load       (load),
        .done       (done),
        .result     (result)
    );

    hchain_nib_pick #(.N_STG(STAGES), .DW(ENG_W)) u_pick (
        .sel_word  (sel_q),
        .stage_idx (stage),
        .digit     (digit)
    );

    hchain_distinct #(.N_STG(STAGES), .DW(ENG_W)) u_dist (
        .sel_word (selector),
        .count    (cnt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q        <= '0;
            distinct_cnt <= '0;
        end else if (load) begin
            sel_q        <= selector;
            distinct_cnt <= cnt_next;
        end
    end

    assign req.engine = digit;
    assign req.data   = cur_data;

    assign busy       = (state != CS_IDLE);
    assign req_valid  = (state == CS_ISSUE);
    assign req_engine = req.engine;
    assign req_data   = req.data;
endmodule

// File: rtl/hchain_seq_checker.sv
module hchain_seq_checker
    import hchain_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  distinct_cnt,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ENG_W-1:0]  req_engine,
    input logic [DATA_W-1:0] req_data
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!req_valid && !busy && !done && distinct_cnt == '0));

    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_engine) && $stable(req_data)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_start_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(distinct_cnt));

    a_r9_count_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (distinct_cnt >= CNT_W'(1) && distinct_cnt <= CNT_W'(ENG_TYPES)));
endmodule

bind hchain_seq hchain_seq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .distinct_cnt (distinct_cnt),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_engine   (req_engine),
    .req_data     (req_data)
);

// File: tb/hchain_seq_tb.sv
`timescale 1ns/1ps
module hchain_seq_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [63:0]  selector;
    logic [511:0] msg_in;
    logic         busy, done;
    logic [511:0] result;
    logic [4:0]   distinct_cnt;
    logic         req_valid, req_ready;
    logic [3:0]   req_engine;
    logic [511:0] req_data;
    logic         resp_valid;
    logic [511:0] resp_data;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    hchain_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .selector(selector), .msg_in(msg_in),
        .busy(busy), .done(done), .result(result), .distinct_cnt(distinct_cnt),
        .req_valid(req_valid), .req_ready(req_ready), .req_engine(req_engine),
        .req_data(req_data), .resp_valid(resp_valid), .resp_data(resp_data)
    );

    task automatic chk(input logic ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] eng_model(input logic [3:0] e, input logic [511:0] d);
        int r;
        logic [31:0] k;
        r = int'(e) * 7 + 1;
        k = 32'h9E3779B9 * (32'(e) + 32'd1);
        return ((d << r) | (d >> (512 - r))) ^ {16{k}};
    endfunction

    function automatic logic [4:0] exp_distinct(input logic [63:0] s);
        logic [15:0] seen = '0;
        int n = 0;
        for (int i = 0; i < 16; i++) seen[s[i*4 +: 4]] = 1'b1;
        for (int i = 0; i < 16; i++) n += int'(seen[i]);
        return 5'(n);
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // mode bit0: stray response before acceptance; bit1: second start mid-chain
    task automatic run_chain(input logic [63:0] sel, input logic [511:0] msg, input int mode);
        logic [511:0] cur;
        logic [3:0]   eng;
        logic [4:0]   dexp;
        dexp = exp_distinct(sel);
        @(negedge clk);
        start = 1'b1; selector = sel; msg_in = msg;
        @(negedge clk);
        start = 1'b0; selector = {$urandom, $urandom}; msg_in = rnd512();
        chk(busy == 1'b1, "R2 busy after start", 512'(busy), 512'(1));
        chk(distinct_cnt == dexp, "R9 distinct count", 512'(distinct_cnt), 512'(dexp));
        cur = msg;
        for (int k = 0; k < 16; k++) begin
            eng = sel[63 - 4*k -: 4];
            chk(req_valid == 1'b1, "R4 request issued", 512'(req_valid), 512'(1));
            chk(req_engine == eng, "R3 engine order", 512'(req_engine), 512'(eng));
            chk(req_data == cur, (k == 0) ? "R2 first data" : "R4 chained data", req_data, cur);
            if ((mode & 1) != 0 && k == 4) begin
                resp_valid = 1'b1; resp_data = rnd512();
                @(negedge clk);
                resp_valid = 1'b0;
                chk(req_valid == 1'b1 && req_data == cur, "R6 stray response ignored", req_data, cur);
            end
            for (int w = 0; w < int'($urandom % 3); w++) begin
                @(negedge clk);
                chk(req_valid && req_engine == eng && req_data == cur, "R5 request held", req_data, cur);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(req_valid == 1'b0, "R4 one outstanding", 512'(req_valid), 512'(0));
            if ((mode & 2) != 0 && k == 7) begin
                start = 1'b1; selector = ~sel; msg_in = rnd512();
                @(negedge clk);
                start = 1'b0;
                chk(distinct_cnt == dexp, "R8 start while busy", 512'(distinct_cnt), 512'(dexp));
            end
            for (int w = 0; w < int'($urandom % 3); w++) @(negedge clk);
            cur = eng_model(eng, cur);
            resp_valid = 1'b1; resp_data = cur;
            @(negedge clk);
            resp_valid = 1'b0; resp_data = rnd512();
            if (k < 15) chk(done == 1'b0, "R7 no early done", 512'(done), 512'(0));
        end
        chk(done == 1'b1 && busy == 1'b0, "R7 done pulse", 512'({done, busy}), 512'(2'b10));
        chk(result == cur, "R7 result", result, cur);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", 512'(done), 512'(0));
        chk(result == cur, "R7 result held", result, cur);
        chk(distinct_cnt == dexp, "R9 count held", 512'(distinct_cnt), 512'(dexp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired, all requirements actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; selector = '0; msg_in = '0;
        req_ready = 1'b0; resp_valid = 1'b0; resp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!req_valid && !busy && !done && distinct_cnt == 5'd0, "R1 reset state",
            512'({req_valid, busy, done, distinct_cnt}), 512'(0));

        run_chain(64'h0123456789ABCDEF, rnd512(), 0);
        run_chain(64'h0000000000000000, rnd512(), 0);
        run_chain(64'hF0F0F0F00F0F0F0F, rnd512(), 1);
        run_chain(64'h3A3A3A3A3A3A3A3A, rnd512(), 2);
        run_chain(64'hFEDCBA9876543210, rnd512(), 3);

        // reset in the middle of a chain
        @(negedge clk);
        start = 1'b1; selector = 64'h1122334455667788; msg_in = rnd512();
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!req_valid && !busy && !done && distinct_cnt == 5'd0, "R1 mid-chain reset",
            512'({req_valid, busy, done, distinct_cnt}), 512'(0));
        run_chain(64'h9876FEDC01234567, rnd512(), 0);

        for (int t = 0; t < 20; t++) begin
            run_chain({$urandom, $urandom}, rnd512(), int'($urandom % 4));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule